// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is the arithmetic and logic stage of a small two-operand microcontroller datapath. Each operation takes a destination operand and a source operand. It returns a result in the same cycle, along with a write-back enable that tells the datapath whether to store that result. The carry, zero, negative and overflow status bits are held in registers. They are updated on the clock edge that ends a valid operation.

Operands are either a full word or the low byte, chosen per operation. Subtraction is done by adding the inverted source. The carry flag is therefore 1 when no borrow occurred. The carry-chained add and subtract use the stored carry flag as their carry-in. Compare and bit test only set the flags and never request a write-back. Register file, decode and memory access lie outside the block.

Top module: `aluStatusUnit`

## Requirements
- R1: While `rstN` is low, and after it is released before any valid operation, `flagC`, `flagZ`, `flagN` and `flagV` are all 0.
- R2: Opcode 0 gives dest + src. Opcode 1 gives dest + src + stored C. Carry is set when the unsigned sum exceeds the operand width.
- R3: Opcode 2 gives dest + ~src + 1. Opcode 3 gives dest + ~src + stored C. In both, C is set when no borrow occurred, that is when unsigned dest >= src plus the pending borrow. Opcode 4 computes the same flags as opcode 2.
- R4: For opcodes 0 to 4, V is set when the signed result does not fit in the operand width.
- R5: The logic opcodes give these results: 5 is dest AND src, 6 is dest OR src, 7 is dest XOR src, 8 is NOT dest, 9 is dest AND NOT src (mask clear), 10 is dest OR src (mask set) and 11 is dest AND src (bit test).
- R6: After any of opcodes 5 to 11, V is 0 and C is the inverse of Z.
- R7: Z is set when the sized result is zero. N copies the sign bit of the sized result, which is bit 7 in byte mode and bit 15 in word mode.
- R8: With `isByte` = 1, only the low 8 bits of each operand are used. The upper 8 result bits are 0, and carry and overflow come from the 8-bit operation.
- R9: `wbEn` is 1 only while `opValid` is 1 and the opcode is one of 0-3 or 5-10. For compare (4) and bit test (11) it is 0.
- R10: The flags change only on a rising clock edge where `opValid` is 1. Otherwise they hold their value.
- R11: Opcodes 12 to 15 leave the flags unchanged, hold `wbEn` at 0 and return the sized destination as the result.
- R12: `result` is combinational: it reflects the present inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation select (encoding in R2-R5, R11) |
| isByte | input | 1 | 1 = byte operands, 0 = word operands |
| dstIn | input | 16 | Destination operand |
| srcIn | input | 16 | Source operand or mask |
| result | output | 16 | Sized result, combinational |
| wbEn | output | 1 | Write the result back to the destination |
| flagC | output | 1 | Carry / no-borrow flag |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Signed overflow flag |

## Verification
The bound assertions check the following on every cycle:
- flags hold when no valid operation is presented, and for unused opcodes;
- write-back is suppressed for compare and bit test;
- the upper byte is zero in byte mode;
- the zero flag agrees with the previous cycle's result;
- the logic-flag rule C = !Z with V = 0.

Some behaviours can only be shown by the bench's scenarios, because they need an arithmetic reference:
- the exact sums, differences and carries;
- signed-overflow boundaries such as 0x7F + 1 in byte mode;
- chaining of the stored carry through add-with-carry and subtract-with-borrow.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8,
    OP_CLR  = 4'd9,
    OP_SET  = 4'd10,
    OP_TEST = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_OR   = 3'd1,
    LG_XOR  = 3'd2,
    LG_NOT  = 3'd3,
    LG_CLR  = 3'd4,
    LG_PASS = 3'd5
  } logicSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      useAdder;
    logic      invSrc;
    cinSel_e   cinSel;
    logicSel_e logicSel;
    logic      wbEn;
    logic      flagEn;
  } ctrlStrobe_t;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } aluFlags_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [3:0]  opCode,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.useAdder = 1'b0;
    strobe.invSrc   = 1'b0;
    strobe.cinSel   = CIN_ZERO;
    strobe.logicSel = LG_PASS;
    strobe.wbEn     = 1'b0;
    strobe.flagEn   = 1'b0;
    case (opCode)
      OP_ADD: begin
        strobe.useAdder = 1'b1;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      OP_ADDC: begin
        strobe.useAdder = 1'b1;
        strobe.cinSel   = CIN_FLAG;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        strobe.useAdder = 1'b1;
        strobe.invSrc   = 1'b1;
        strobe.cinSel   = CIN_ONE;
        strobe.wbEn     = (opCode == OP_SUB);
        strobe.flagEn   = 1'b1;
      end
      OP_SUBC: begin
        strobe.useAdder = 1'b1;
        strobe.invSrc   = 1'b1;
        strobe.cinSel   = CIN_FLAG;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      OP_AND, OP_TEST: begin
        strobe.logicSel = LG_AND;
        strobe.wbEn     = (opCode == OP_AND);
        strobe.flagEn   = 1'b1;
      end
      OP_OR, OP_SET: begin
        strobe.logicSel = LG_OR;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      OP_XOR: begin
        strobe.logicSel = LG_XOR;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      OP_NOT: begin
        strobe.logicSel = LG_NOT;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      OP_CLR: begin
        strobe.logicSel = LG_CLR;
        strobe.wbEn     = 1'b1;
        strobe.flagEn   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 16
)(
  input  ctrlStrobe_t       strobe,
  input  logic              isByte,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic              carryFlag,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         nextFlags
);

  localparam int NARROW_W = DATA_W / 2;
  localparam int UPPER_W  = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   opB;
  logic                cin;
  logic [DATA_W:0]     sumWide;
  logic [NARROW_W:0]   sumNarrow;
  logic [DATA_W-1:0]   logicRaw;
  logic [DATA_W-1:0]   rawRes;
  logic                carryOut;
  logic                ovfOut;
  logic                signA;
  logic                signB;
  logic                signS;
  logic                resZero;
  logic                resNeg;

  assign opB = strobe.invSrc ? ~srcIn : srcIn;

  always_comb begin
    case (strobe.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryFlag;
      default:  cin = 1'b0;
    endcase
  end

  // one adder sized for the word, a narrow one for the byte carry
  assign sumWide   = {1'b0, dstIn} + {1'b0, opB} + {{DATA_W{1'b0}}, cin};
  assign sumNarrow = {1'b0, dstIn[NARROW_W-1:0]} + {1'b0, opB[NARROW_W-1:0]}
                   + {{NARROW_W{1'b0}}, cin};

  always_comb begin
    if (isByte) begin
      carryOut = sumNarrow[NARROW_W];
      signA    = dstIn[NARROW_W-1];
      signB    = opB[NARROW_W-1];
      signS    = sumNarrow[NARROW_W-1];
    end else begin
      carryOut = sumWide[DATA_W];
      signA    = dstIn[DATA_W-1];
      signB    = opB[DATA_W-1];
      signS    = sumWide[DATA_W-1];
    end
    ovfOut = (signA == signB) && (signS != signA);
  end

  always_comb begin
    case (strobe.logicSel)
      LG_AND:  logicRaw = dstIn & srcIn;
      LG_OR:   logicRaw = dstIn | srcIn;
      LG_XOR:  logicRaw = dstIn ^ srcIn;
      LG_NOT:  logicRaw = ~dstIn;
      LG_CLR:  logicRaw = dstIn & ~srcIn;
      default: logicRaw = dstIn;
    endcase
  end

  assign rawRes = strobe.useAdder ? sumWide[DATA_W-1:0] : logicRaw;
  assign result = isByte ? {{UPPER_W{1'b0}}, rawRes[NARROW_W-1:0]} : rawRes;

  assign resZero = (result == '0);
  assign resNeg  = isByte ? result[NARROW_W-1] : result[DATA_W-1];

  always_comb begin
    nextFlags.z = resZero;
    nextFlags.n = resNeg;
    nextFlags.c = strobe.useAdder ? carryOut : ~resZero;
    nextFlags.v = strobe.useAdder ? ovfOut : 1'b0;
  end

endmodule

// File: rtl/aluFlagReg.sv
module aluFlagReg
  import aluPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      load,
  input  aluFlags_t nextFlags,
  output aluFlags_t flags
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     flags <= '0;
    else if (load) flags <= nextFlags;
  end

endmodule

// File: rtl/aluStatusUnit.sv
module aluStatusUnit
  import aluPkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic              isByte,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] result,
  output logic              wbEn,
  output logic              flagC,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagV
);

  ctrlStrobe_t strobe;
  aluFlags_t   nextFlags;
  aluFlags_t   flags;

  aluCtrl uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  aluDatapath #(.DATA_W(DATA_W)) uPath (
    .strobe    (strobe),
    .isByte    (isByte),
    .dstIn     (dstIn),
    .srcIn     (srcIn),
    .carryFlag (flags.c),
    .result    (result),
    .nextFlags (nextFlags)
  );

  aluFlagReg uFlags (
    .clk       (clk),
    .rstN      (rstN),
    .load      (opValid & strobe.flagEn),
    .nextFlags (nextFlags),
    .flags     (flags)
  );

  assign wbEn  = opValid & strobe.wbEn;
  assign flagC = flags.c;
  assign flagZ = flags.z;
  assign flagN = flags.n;
  assign flagV = flags.v;

endmodule

// File: rtl/aluStatusUnitChk.sv
module aluStatusUnitChk
  import aluPkg::*;
#(
  parameter int DATA_W = 16
)(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic              isByte,
  input logic [DATA_W-1:0] dstIn,
  input logic [DATA_W-1:0] result,
  input logic              wbEn,
  input logic              flagC,
  input logic              flagZ,
  input logic              flagN,
  input logic              flagV
);

  localparam int NARROW_W = DATA_W / 2;

  // R9
  no_wb_on_compare_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_CMP || opCode == OP_TEST) |-> !wbEn);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable({flagC, flagZ, flagN, flagV}));

  // R11
  unused_code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode > OP_TEST) |=> $stable({flagC, flagZ, flagN, flagV}));

  // R11
  unused_code_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode > OP_TEST) |-> (!wbEn && result == (isByte ?
      {{(DATA_W-NARROW_W){1'b0}}, dstIn[NARROW_W-1:0]} : dstIn)));

  // R8
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    isByte |-> (result[DATA_W-1:NARROW_W] == '0));

  // R7
  zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode <= OP_TEST) |=> (flagZ == ($past(result) == '0)));

  // R6
  logic_flag_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= OP_AND && opCode <= OP_TEST) |=> (!flagV && flagC == !flagZ));

  // R5
  invert_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_NOT && !isByte) |-> (result == ~dstIn));

endmodule

bind aluStatusUnit aluStatusUnitChk #(.DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .isByte  (isByte),
  .dstIn   (dstIn),
  .result  (result),
  .wbEn    (wbEn),
  .flagC   (flagC),
  .flagZ   (flagZ),
  .flagN   (flagN),
  .flagV   (flagV)
);

// File: tb/aluStatusUnit_test.sv
module aluStatusUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic        isByte = 1'b0;
  logic [15:0] dstIn = 16'd0;
  logic [15:0] srcIn = 16'd0;
  logic [15:0] result;
  logic        wbEn;
  logic        flagC, flagZ, flagN, flagV;

  int checkCnt = 0;
  int failCnt  = 0;
  logic mC = 0, mZ = 0, mN = 0, mV = 0;

  always #10 clk = ~clk;

  aluStatusUnit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .isByte(isByte), .dstIn(dstIn), .srcIn(srcIn), .result(result),
    .wbEn(wbEn), .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );

  task automatic check(string req, int act, int expv);
    checkCnt++;
    if (act != expv) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // reference model computed from the requirements with signed/unsigned integers
  task automatic model(input int op, input bit byt, input int d, input int s, input bit cinF,
                       output int res, output bit c, output bit v, output bit wb, output bit upd);
    int mask, half, ud, us, sd, ss, sv, b;
    mask = byt ? 32'hFF : 32'hFFFF;
    half = byt ? 128 : 32768;
    ud = d & mask; us = s & mask;
    sd = (ud >= half) ? ud - 2*half : ud;
    ss = (us >= half) ? us - 2*half : us;
    c = 0; v = 0; res = ud;
    case (op)
      0, 1: begin
        b = (op == 1) ? int'(cinF) : 0;
        res = (ud + us + b) & mask;
        c = (ud + us + b) > mask;
        sv = sd + ss + b;
        v = (sv > half - 1) || (sv < -half);
      end
      2, 3, 4: begin
        b = (op == 3) ? 1 - int'(cinF) : 0;
        res = (ud - us - b) & mask;
        c = ud >= us + b;
        sv = sd - ss - b;
        v = (sv > half - 1) || (sv < -half);
      end
      5, 11: res = ud & us;
      6, 10: res = ud | us;
      7:     res = ud ^ us;
      8:     res = (~ud) & mask;
      9:     res = ud & ~us & mask;
      default: res = ud;
    endcase
    if (op >= 5) c = (res != 0);
    wb  = (op <= 11) && (op != 4) && (op != 11);
    upd = (op <= 11);
  endtask

  function automatic string resTag(int op, bit byt);
    if (byt) return "R8";
    if (op <= 1) return "R2";
    if (op <= 4) return "R3";
    if (op <= 11) return "R5";
    return "R11";
  endfunction

  task automatic runOp(int op, bit byt, int d, int s, bit valid);
    int  res;
    bit  c, v, wb, upd, z, n;
    @(negedge clk);
    opValid = valid; opCode = op[3:0]; isByte = byt;
    dstIn = d[15:0]; srcIn = s[15:0];
    model(op, byt, d, s, mC, res, c, v, wb, upd);
    #2;
    // R12: result is present in the same cycle
    check(resTag(op, byt), int'(result), res);
    check("R9", int'(wbEn), int'(wb && valid));
    if (byt) check("R8", int'(result[15:8]), 0);
    z = (res == 0);
    n = byt ? res[7] : res[15];
    if (valid && upd) begin
      mC = c; mZ = z; mN = n; mV = v;
    end
    @(posedge clk);
    #2;
    if (!valid) begin
      check("R10", int'({flagC, flagZ, flagN, flagV}), int'({mC, mZ, mN, mV}));
    end else if (!upd) begin
      check("R11", int'({flagC, flagZ, flagN, flagV}), int'({mC, mZ, mN, mV}));
    end else begin
      check(op <= 1 ? "R2" : (op <= 4 ? "R3" : "R6"), int'(flagC), int'(mC));
      check(op <= 4 ? "R4" : "R6", int'(flagV), int'(mV));
      check("R7", int'(flagZ), int'(mZ));
      check("R7", int'(flagN), int'(mN));
    end
  endtask

  initial begin
    void'($urandom(32'h0C0FFEE5));
    #5;
    // R1: reset state
    check("R1", int'({flagC, flagZ, flagN, flagV}), 0);
    repeat (3) @(posedge clk);
    #3 rstN = 1'b1;
    @(negedge clk);
    check("R1", int'({flagC, flagZ, flagN, flagV}), 0);

    // directed corners
    runOp(0, 0, 16'hFFFF, 16'h0001, 1);   // R2 word wrap to zero with carry
    runOp(1, 0, 16'h0001, 16'h0001, 1);   // R2 add with stored carry 1 -> 3
    runOp(0, 1, 16'h007F, 16'h0001, 1);   // R4 R8 byte signed overflow
    runOp(0, 0, 16'h7FFF, 16'h0001, 1);   // R4 word signed overflow
    runOp(2, 0, 16'h0005, 16'h0005, 1);   // R3 equal -> zero, no borrow
    runOp(2, 0, 16'h0000, 16'h0001, 1);   // R3 borrow, C = 0
    runOp(3, 0, 16'h0010, 16'h0001, 1);   // R3 pending borrow -> 0x000E
    runOp(2, 1, 16'h1280, 16'hAB01, 1);   // R4 R8 byte 0x80 - 1 overflow
    runOp(4, 0, 16'h1234, 16'h1234, 1);   // R9 compare, flags only
    runOp(11, 0, 16'h00F0, 16'h000F, 1);  // R9 bit test zero, C = 0
    runOp(9, 0, 16'hFFFF, 16'h0012, 1);   // R5 mask clear
    runOp(10, 1, 16'hAB00, 16'h0012, 1);  // R5 mask set in byte mode
    runOp(8, 0, 16'hFFFF, 16'h0000, 1);   // R5 R6 invert to zero
    runOp(7, 0, 16'hFFFF, 16'h8000, 1);   // R5 toggle
    runOp(13, 0, 16'h8001, 16'h0000, 1);  // R11 unused code
    runOp(0, 0, 16'h0001, 16'h0001, 0);   // R10 idle cycle

    for (int i = 0; i < 2000; i++) begin
      runOp(int'($urandom % 16), bit'($urandom % 2),
            int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF),
            ($urandom % 8) != 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule